// File: doc/BRIEF.md
# Pulse input glitch filter

This block cleans up a pulse source before a pulse counter sees it. The raw pin is first mapped to an "asserted" sense by a polarity select and then passed through a two-flop synchronizer. All of this runs on rising edges of the prescaler clock, which is the block's only clock. In filter mode the conditioned level only takes on a new value once the synchronized sample has disagreed with it for 2^N consecutive edges. N is set by a select input in the range 1 to 15. In bypass mode the synchronized sample drives the conditioned level directly.

The block gives three outputs. One is the conditioned level in asserted sense. One is the same level at the physical polarity. The third is a single-cycle count pulse for each low-to-high change of the asserted level, and this pulse clocks the downstream counter. While the block is disabled, the whole chain is held in the asserted state. Enabling the block with the pin already active therefore never yields a spurious count, in either mode.

Top module: `pgf_filter`

## Requirements
- R1: In bypass mode (bypass=1), a pin level first present at rising edge k appears on filt_act after edge k+2, because of the two synchronizer stages.
- R2: In filter mode, after the pin turns deasserted at edge k and stays deasserted, filt_act falls after edge k+1+2^N and not earlier.
- R3: In filter mode, after the pin turns asserted at edge k and stays asserted, filt_act rises after edge k+1+2^N and not earlier.
- R4: In filter mode, a run of differing samples shorter than 2^N leaves filt_act unchanged. A sample equal to filt_act restarts the run count from zero.
- R5: While enable=0, filt_act is 1 and filt_out shows the asserted physical level, which is 1 with active_low=0 and 0 with active_low=1.
- R6: active_low=1 treats a low pin as asserted. filt_out always equals filt_act XOR active_low.
- R7: With the pin already asserted when enable rises, no count pulse is produced and filt_act stays 1, in both bypass and filter mode.
- R8: cnt_pulse is high for exactly one cycle, in the first cycle that filt_act reads 1 after reading 0, and is low at all other times.
- R9: width_sel (N) uses values 1 to 15 directly, and a width_sel of 0 behaves as N=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low holds everything asserted |
| bypass | input | 1 | 1 selects pass-through, 0 selects filtering |
| active_low | input | 1 | 1 means a low pin level is asserted |
| width_sel | input | SEL_W (4) | Filter exponent N; run length is 2^N samples |
| pulse_in | input | 1 | Raw pulse source |
| filt_out | output | 1 | Conditioned level at pin polarity |
| filt_act | output | 1 | Conditioned level in asserted sense |
| cnt_pulse | output | 1 | One-cycle pulse per assertion of filt_act |

## Verification
The bench measures the exact edge at which the conditioned level flips, for several N values including 0, 1 and 15. A design with one counter value too many or too few shifts that edge by one. A design that skips a synchronizer stage shifts it by one. Glitches exactly one sample shorter than 2^N are aimed at a filter that flips early or fails to clear its run count. The bench also enables the block with the pin already active, in both modes and both polarities. A design that does not preset the synchronizer would then emit a stray count pulse.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

   typedef enum logic {
      PGF_MODE_FILTER = 1'b0,
      PGF_MODE_BYPASS = 1'b1
   } pgf_mode_e;

   // exponent actually applied: zero promotes to one, large values clip
   function automatic int unsigned pgf_eff_exp(input int unsigned sel, input int unsigned max_sel);
      if (sel == 0)
         return 1;
      else if (sel > max_sel)
         return max_sel;
      else
         return sel;
   endfunction

endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pgf_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   // preset to asserted while disabled, so that enabling never looks like an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain <= '1;
      else if (!en)
         chain <= '1;
      else
         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pgf_stab.sv
module pgf_stab
   import pgf_pkg::*;
#(
   parameter int MAX_SEL = 15,
   parameter int SEL_W   = $clog2(MAX_SEL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  pgf_mode_e        mode,
   input  logic [SEL_W-1:0] sel,
   input  logic             samp,
   output logic             act,
   output logic             rise
);

   localparam int CNT_W = MAX_SEL;

   generate
      if (MAX_SEL < 1) begin : g_bad_max
         $error("pgf_stab needs MAX_SEL of at least one");
      end
      if ((1 << SEL_W) <= MAX_SEL) begin : g_bad_selw
         $error("pgf_stab select width cannot hold MAX_SEL");
      end
   endgenerate

   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] nxt_cnt;
   logic [CNT_W-1:0] lim_m1;
   logic [CNT_W:0]   span;
   logic             nxt_act;
   int unsigned      n_eff;

   always_comb begin
      n_eff  = pgf_eff_exp(int'(sel), MAX_SEL);
      span   = (CNT_W+1)'(1) << n_eff;
      lim_m1 = CNT_W'(span - 1'b1);
   end

   always_comb begin
      nxt_act = act;
      nxt_cnt = '0;
      if (!en) begin
         nxt_act = 1'b1;
      end else if (mode == PGF_MODE_BYPASS) begin
         nxt_act = samp;
      end else if (samp != act) begin
         if (run_cnt >= lim_m1)
            nxt_act = samp;
         else
            nxt_cnt = run_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= 1'b1;
         run_cnt <= '0;
         rise    <= 1'b0;
      end else begin
         act     <= nxt_act;
         run_cnt <= nxt_cnt;
         rise    <= en & nxt_act & ~act;
      end
   end

   // R4: without a full run of differing samples the level holds
   assert_hold_short_run_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == PGF_MODE_FILTER && (samp == act || run_cnt < lim_m1)) |=> $stable(act));

   // R4: an agreeing sample restarts the run
   assert_run_restart_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && samp == act) |=> (run_cnt == '0));

   // R5: disabled means asserted with an empty run
   assert_idle_asserted_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (act && run_cnt == '0));

endmodule

// File: rtl/pgf_filter.sv
module pgf_filter
   import pgf_pkg::*;
#(
   parameter int MAX_SEL     = 15,
   parameter int SEL_W       = $clog2(MAX_SEL + 1),
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             bypass,
   input  logic             active_low,
   input  logic [SEL_W-1:0] width_sel,
   input  logic             pulse_in,
   output logic             filt_out,
   output logic             filt_act,
   output logic             cnt_pulse
);

   logic      pin_asserted;
   logic      sync_q;
   logic      act;
   logic      rise;
   pgf_mode_e mode;

   assign pin_asserted = pulse_in ^ active_low;
   assign mode         = bypass ? PGF_MODE_BYPASS : PGF_MODE_FILTER;

   pgf_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (enable),
      .d    (pin_asserted),
      .q    (sync_q)
   );

   pgf_stab #(
      .MAX_SEL(MAX_SEL),
      .SEL_W  (SEL_W)
   ) u_stab (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (enable),
      .mode (mode),
      .sel  (width_sel),
      .samp (sync_q),
      .act  (act),
      .rise (rise)
   );

   assign filt_act  = act;
   assign filt_out  = act ^ active_low;
   assign cnt_pulse = rise;

   // R8: a count pulse marks a fresh assertion
   assert_pulse_on_rise_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse |-> (filt_act && !$past(filt_act)));

   // R8: never two pulses back to back
   assert_pulse_single_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse |=> !cnt_pulse);

   // R7: the first cycle after enabling never counts
   assert_no_count_at_enable_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !cnt_pulse);

endmodule

// File: tb/test_pgf_filter.sv
module test_pgf_filter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       bypass = 1'b0;
   logic       active_low = 1'b0;
   logic [3:0] width_sel = 4'd1;
   logic       pulse_in = 1'b0;
   logic       filt_out;
   logic       filt_act;
   logic       cnt_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   bit m_d1 = 1, m_d2 = 1, m_act = 1, m_pulse = 0;
   int m_run = 0;

   always #5 clk = ~clk;

   pgf_filter i_pgf_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .bypass    (bypass),
      .active_low(active_low),
      .width_sel (width_sel),
      .pulse_in  (pulse_in),
      .filt_out  (filt_out),
      .filt_act  (filt_act),
      .cnt_pulse (cnt_pulse)
   );

   function automatic int span_of(input int sel);
      int n;
      n = (sel == 0) ? 1 : sel;
      return 1 << n;
   endfunction

   task automatic check(input string tag, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // one prescaler edge: update reference from the inputs present, then compare
   task automatic step(input string tag);
      bit prev;
      @(posedge clk);
      if (!enable) begin
         m_d1 = 1; m_d2 = 1; m_act = 1; m_run = 0; m_pulse = 0;
      end else begin
         prev = m_act;
         if (bypass) begin
            m_act = m_d2;
         end else if (m_d2 != m_act) begin
            m_run++;
            if (m_run >= span_of(width_sel)) begin
               m_act = m_d2;
               m_run = 0;
            end
         end else begin
            m_run = 0;
         end
         m_pulse = m_act && !prev;
         m_d2 = m_d1;
         m_d1 = pulse_in ^ active_low;
      end
      @(negedge clk);
      check(tag, "filt_act", filt_act, m_act);
      check(tag, "filt_out", filt_out, m_act ^ active_low);
      check(tag, "cnt_pulse", cnt_pulse, m_pulse);
   endtask

   // set asserted-sense pin level
   task automatic drive(input bit asserted);
      pulse_in = asserted ^ active_low;
   endtask

   // measure edges until filt_act reaches target after a pin change
   task automatic edges_to_flip(input string tag, input bit target, input int limit, output int edges);
      edges = 0;
      for (int i = 1; i <= limit; i++) begin
         step(tag);
         if (filt_act == target && edges == 0) edges = i;
      end
   endtask

   task automatic configure(input bit byp, input bit pol, input int sel);
      @(negedge clk);
      enable = 0;
      step("cfg");
      bypass = byp;
      active_low = pol;
      width_sel = 4'(sel);
   endtask

   initial begin
      int e;
      int pulses;
      void'($urandom(32'd20240611));
      @(negedge clk);
      check("R5", "filt_act in reset", filt_act, 1);
      check("R5", "cnt_pulse in reset", cnt_pulse, 0);
      rst_n = 1;
      step("R5");
      check("R5", "filt_out idle active-high", filt_out, 1);

      // R5/R6: active-low idle level
      configure(0, 1, 2);
      step("R5");
      check("R6", "filt_out idle active-low", filt_out, 0);

      // R2 timing, N=3, active-high
      configure(0, 0, 3);
      drive(1); enable = 1;
      for (int i = 0; i < 6; i++) step("R7");
      drive(0);
      edges_to_flip("R2", 0, 14, e);
      check("R2", "edges to deassert N=3", e, 2 + 8);

      // R3 timing, same config
      drive(1);
      edges_to_flip("R3", 1, 14, e);
      check("R3", "edges to assert N=3", e, 2 + 8);

      // R4: run one short of 2^N
      drive(0);
      for (int i = 0; i < 7; i++) step("R4");
      drive(1);
      for (int i = 0; i < 12; i++) begin
         step("R4");
         check("R4", "level kept after short glitch", filt_act, 1);
      end

      // R4: two short runs separated by one agreeing sample must not add up
      drive(0);
      for (int i = 0; i < 7; i++) step("R4");
      drive(1); step("R4");
      drive(0);
      for (int i = 0; i < 7; i++) step("R4");
      drive(1);
      for (int i = 0; i < 8; i++) begin
         step("R4");
         check("R4", "no carry between runs", filt_act, 1);
      end

      // R9: code 0 behaves like N=1
      configure(0, 0, 0);
      drive(1); enable = 1;
      for (int i = 0; i < 4; i++) step("R9");
      drive(0);
      edges_to_flip("R9", 0, 8, e);
      check("R9", "edges to deassert sel=0", e, 2 + 2);

      // R1: bypass latency, active-low
      configure(1, 1, 5);
      drive(1); enable = 1;
      for (int i = 0; i < 4; i++) step("R1");
      drive(0);
      edges_to_flip("R1", 0, 6, e);
      check("R1", "bypass edges to deassert", e, 3);
      drive(1);
      edges_to_flip("R1", 1, 6, e);
      check("R1", "bypass edges to assert", e, 3);

      // R7: enable with pin asserted, both modes and polarities
      for (int c = 0; c < 4; c++) begin
         configure(c[0], c[1], 1);
         drive(1);
         enable = 1;
         pulses = 0;
         for (int i = 0; i < 10; i++) begin
            step("R7");
            pulses += int'(cnt_pulse);
         end
         check("R7", "pulses after enable", pulses, 0);
         check("R7", "level after enable", filt_act, 1);
      end

      // R8: bypass toggling, count pulses
      configure(1, 0, 1);
      drive(1); enable = 1;
      step("R8");
      pulses = 0;
      for (int k = 0; k < 5; k++) begin
         drive(0); step("R8"); step("R8");
         drive(1); step("R8");
         pulses += int'(cnt_pulse); step("R8");
         pulses += int'(cnt_pulse); step("R8");
         pulses += int'(cnt_pulse);
      end
      check("R8", "pulses for five bypass assertions", pulses, 5);

      // R2 at the widest setting, N=15
      configure(0, 0, 15);
      drive(1); enable = 1;
      step("R2");
      drive(0);
      edges_to_flip("R2", 0, 32775, e);
      check("R2", "edges to deassert N=15", e, 2 + 32768);

      // random segments
      for (int seg = 0; seg < 12; seg++) begin
         int sel;
         int lim;
         sel = $urandom_range(0, 3);
         configure($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, sel);
         lim = span_of(sel);
         drive($urandom_range(0, 1) == 1);
         enable = 1;
         for (int r = 0; r < 60; r++) begin
            int len;
            len = $urandom_range(1, 2 * lim + 3);
            drive($urandom_range(0, 1) == 1);
            for (int j = 0; j < len; j++) step(bypass ? "R1" : "R4");
         end
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule